// File: doc/BRIEF.md
# Paged DRAM Window Controller with Hidden Refresh

This block lets an 8-bit processor with a 16-bit address bus reach a 4M x 8 dynamic memory array. The upper 32K of the processor's address space is a window into DRAM. A 7-bit page register, which the processor writes at a fixed I/O location in the lower half, selects which 32K slice of the 4M array the window shows. The page bits and the low 15 processor address bits form a 22-bit physical address. That address is sent to the memory in two halves over an 11-bit shared address bus. The high-order half goes out first as the row. The low-order half follows as the column.

The controller runs on a fast system clock and watches the processor clock `cpu_phi2`. It assumes `cpu_phi2` is generated synchronously to `clk`. The processor owns the bus while `cpu_phi2` is high. During that phase a window access runs a fixed sequence: row address, RAS, column address, CAS. RAS and CAS are held until the phase ends. While `cpu_phi2` is low, the controller performs one RAS-only refresh, using an internal row counter, so refresh never stalls the processor. A sticky flag reports a processor clock too slow for every row to be refreshed within the 2 ms retention time.

Top module: `paged_dram_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `refresh_slow` is low, the page register holds 0 and the refresh row counter holds 0.
- R2: A processor write (`cpu_rw`=0) to address 0x7F00 with `cpu_phi2` high loads `cpu_wdata[6:0]` into the page register; bit 7 is ignored. A read (`cpu_rw`=1) of 0x7F00 with `cpu_phi2` high drives `map_rd_hit` high and `map_rd_data` = {1'b0, page}.
- R3: A processor cycle with address bit 15 clear keeps both `dram_ras_n` and `dram_cas_n` high during the whole high phase of `cpu_phi2`.
- R4: A cycle with address bit 15 set uses the physical address P = {page[6:0], addr[14:0]}. `dram_addr` shows P[21:11] when `dram_ras_n` falls, shows P[10:0] when `dram_cas_n` falls, and holds steady while CAS stays low.
- R5: Counting posedges from the first one where `cpu_phi2` is sampled high as edge 0: RAS falls after edge 1, the column appears after edge 2, and CAS falls after edge 3. CAS and RAS both rise after the first edge that samples `cpu_phi2` low. CAS is never low while RAS is high.
- R6: On a window write, `dram_we_n` falls together with the column switch, one clock before CAS falls. It rises together with CAS. On a window read it stays high.
- R7: Each `cpu_phi2` cycle gets exactly one RAS-only refresh in its low phase. `dram_ras_n` is low for exactly 2 clocks, `dram_cas_n` stays high, and `dram_addr` shows the refresh row. The refresh starts after the first low-phase edge, or one edge later if that edge ends a window access.
- R8: The refresh row counter advances by one after each refresh and wraps from 2047 to 0.
- R9: `refresh_slow` becomes 1 once a `cpu_phi2` rise-to-rise period exceeds 244 system clocks (2 ms / 2048 rows at 250 MHz). It then stays 1 until reset. A period of exactly 244 clocks leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_phi2 | input | 1 | Processor clock, high = processor bus phase |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Processor write data |
| map_rd_hit | output | 1 | Page register is being read this phase |
| map_rd_data | output | 8 | Page register read-back value |
| dram_addr | output | 11 | Multiplexed row/column/refresh address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| refresh_slow | output | 1 | Sticky: processor clock too slow for refresh |

## Verification
Every DRAM strobe edge falls at a fixed posedge offset from the `cpu_phi2` rise. Within the cycle, RAS falls at offset 1 and CAS at offset 3. Write enable falls at offset 2. The strobes rise at the high-phase length H. Refresh RAS falls at H, or at H+1 after an access, and rises two offsets later. The driver queues each expected edge with its offset and address. A monitor samples one nanosecond after every posedge, keeps its own offset counter from the sampled `cpu_phi2`, and pops and compares an item at each strobe edge it sees. The page read-back is combinational and is checked at the first negedge of the read phase. The slow flag is checked one full cycle after the long period it judges.

// File: rtl/dram_bank_pkg.sv
// Shared types for the paged DRAM window controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dram_bank_pkg;

    // Sequencer states: idle, window access phases, refresh pulse
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADR,
        SQ_ROW,
        SQ_MUX,
        SQ_CAS,
        SQ_REF
    } sq_state_t;

    // Source selection for the shared DRAM address bus
    typedef enum logic [1:0] {
        AM_REF,
        AM_ROW,
        AM_COL
    } amux_sel_t;

endpackage

// File: rtl/bank_page_reg.sv
// Page mapping register.
// Holds the page number that selects which slice of DRAM the processor
// window shows. Writable and readable at one fixed address while phi2 is
// high. Assumes PAGE_W <= CPU_DW and that MAP_ADDR lies outside the window.
module bank_page_reg #(
    parameter int                CPU_AW   = 16,
    parameter int                CPU_DW   = 8,
    parameter int                PAGE_W   = 7,
    parameter logic [CPU_AW-1:0] MAP_ADDR = 16'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [CPU_AW-1:0] addr,
    input  logic              rw,
    input  logic [CPU_DW-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic              rd_hit,
    output logic [CPU_DW-1:0] rd_data
);

    logic hit;
    logic wr_en;

    assign hit    = (addr == MAP_ADDR);
    assign wr_en  = phi2 && hit && !rw;
    assign rd_hit = phi2 && hit && rw;

    // Load the page number on a processor write to the mapping address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (wr_en) begin
            page <= wdata[PAGE_W-1:0];
        end
    end

    // Read-back path: zero-pad the page number to the data width
    generate
        if (CPU_DW > PAGE_W) begin : g_pad
            logic unused_wd_hi;
            assign unused_wd_hi = ^wdata[CPU_DW-1:PAGE_W];
            assign rd_data      = {{(CPU_DW-PAGE_W){1'b0}}, page};
        end else begin : g_full
            assign rd_data = page;
        end
    endgenerate

endmodule

// File: rtl/bank_addr_split.sv
// Physical address former and multiplexer.
// Latches {page, offset} at the start of a window access. Then drives the
// high-order half (row), the low-order half (column) or the refresh row
// onto the shared DRAM address bus. Assumes PAGE_W + OFS_W == 2 * MA_W.
module bank_addr_split
    import dram_bank_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int OFS_W  = 15,
    parameter int MA_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  offset,
    input  amux_sel_t         sel,
    input  logic [MA_W-1:0]   ref_row,
    output logic [MA_W-1:0]   ma
);

    localparam int PHYS_W = PAGE_W + OFS_W;

    logic [PHYS_W-1:0] phys_q;
    logic [MA_W-1:0]   row_half;
    logic [MA_W-1:0]   col_half;

    // Capture the physical address so it stays steady through the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q <= '0;
        end else if (load) begin
            phys_q <= {page, offset};
        end
    end

    assign row_half = phys_q[PHYS_W-1 -: MA_W];
    assign col_half = phys_q[MA_W-1:0];

    // Select which address half or the refresh row is on the bus
    always_comb begin
        case (sel)
            AM_ROW:  ma = row_half;
            AM_COL:  ma = col_half;
            default: ma = ref_row;
        endcase
    end

endmodule

// File: rtl/bank_access_seq.sv
// Strobe sequencer with hidden refresh.
// During phi2 high, a window hit runs: address setup, RAS, column switch,
// CAS, then hold until phi2 falls. During phi2 low, one RAS-only refresh
// of REF_CLKS clocks runs from an internal row counter. Strobes are decoded
// from the state register. Assumes phi2 is synchronous to clk, the high
// phase lasts at least 4 clocks and REF_CLKS >= 2.
module bank_access_seq
    import dram_bank_pkg::*;
#(
    parameter int REF_CLKS = 2,
    parameter int MA_W     = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phi2,
    input  logic            phi2_rise,
    input  logic            win_sel,
    input  logic            cpu_rw,
    output logic            load_addr,
    output amux_sel_t       amux,
    output logic [MA_W-1:0] ref_row,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n
);

    localparam int RC_W = (REF_CLKS > 1) ? $clog2(REF_CLKS) : 1;

    sq_state_t       st;
    sq_state_t       st_nx;
    logic [RC_W-1:0] rcnt;
    logic            ref_pend;
    logic            ref_last;
    logic            wr_q;

    assign ref_last  = (st == SQ_REF) && (rcnt == RC_W'(REF_CLKS - 1));
    assign load_addr = (st == SQ_IDLE) && phi2 && win_sel;

    // Next-state choice: access has the high phase, refresh the low phase
    always_comb begin
        st_nx = st;
        case (st)
            SQ_IDLE: begin
                if (phi2 && win_sel)       st_nx = SQ_ADR;
                else if (!phi2 && ref_pend) st_nx = SQ_REF;
            end
            SQ_ADR:  st_nx = SQ_ROW;
            SQ_ROW:  st_nx = SQ_MUX;
            SQ_MUX:  st_nx = SQ_CAS;
            SQ_CAS:  if (!phi2) st_nx = SQ_IDLE;
            SQ_REF:  if (ref_last) st_nx = SQ_IDLE;
            default: st_nx = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    // Remember whether the window access being run is a write
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_q <= 1'b0;
        else if (load_addr) wr_q <= !cpu_rw;
    end

    // Count the length of the refresh RAS pulse
    always_ff @(posedge clk) begin
        if (!rst_n || st != SQ_REF) rcnt <= '0;
        else                        rcnt <= rcnt + 1'b1;
    end

    // One refresh owed per processor cycle: armed on rise, cleared when done
    always_ff @(posedge clk) begin
        if (!rst_n)         ref_pend <= 1'b0;
        else if (phi2_rise) ref_pend <= 1'b1;
        else if (ref_last)  ref_pend <= 1'b0;
    end

    // Refresh row counter, wraps at the top row
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_row <= '0;
        else if (ref_last) ref_row <= ref_row + 1'b1;
    end

    // Strobe and mux decode from the registered state
    always_comb begin
        ras_n = !(st == SQ_ROW || st == SQ_MUX || st == SQ_CAS || st == SQ_REF);
        cas_n = !(st == SQ_CAS);
        we_n  = !(wr_q && (st == SQ_MUX || st == SQ_CAS));
        case (st)
            SQ_ADR, SQ_ROW: amux = AM_ROW;
            SQ_MUX, SQ_CAS: amux = AM_COL;
            default:        amux = AM_REF;
        endcase
    end

endmodule

// File: rtl/bank_rate_mon.sv
// Refresh rate monitor.
// Measures each phi2 rise-to-rise period in system clocks. Raises a sticky
// flag when a period exceeds MAX_CYC_CLKS, because one refresh per cycle
// would then not cover every row within the retention time.
module bank_rate_mon #(
    parameter int MAX_CYC_CLKS = 244
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2_rise,
    output logic slow
);

    localparam int CW = $clog2(MAX_CYC_CLKS + 1);

    logic [CW-1:0] cnt;
    logic          at_limit;

    assign at_limit = (cnt == CW'(MAX_CYC_CLKS - 1));

    // Clocks since the last phi2 rise, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || phi2_rise) cnt <= '0;
        else if (!at_limit)      cnt <= cnt + 1'b1;
    end

    // Sticky flag: set when a period runs past the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                     slow <= 1'b0;
        else if (at_limit && !phi2_rise) slow <= 1'b1;
    end

endmodule

// File: rtl/paged_dram_ctrl.sv
// Paged DRAM window controller, top level.
// Maps the upper half of a 16-bit processor space onto a 4M x 8 DRAM
// through a page register. Multiplexes row and column on one address bus,
// sequences RAS/CAS/WE and hides one refresh in every phi2 low phase.
// Assumes phi2 is synchronous to clk and MAP_ADDR has bit 15 clear.
module paged_dram_ctrl
    import dram_bank_pkg::*;
#(
    parameter int                CPU_AW       = 16,
    parameter int                CPU_DW       = 8,
    parameter int                PAGE_W       = 7,
    parameter int                MA_W         = 11,
    parameter logic [CPU_AW-1:0] MAP_ADDR     = 16'h7F00,
    parameter int                REF_CLKS     = 2,
    parameter int                SYS_CLK_KHZ  = 250000,
    parameter int                RETENTION_MS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_phi2,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic              map_rd_hit,
    output logic [CPU_DW-1:0] map_rd_data,
    output logic [MA_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              refresh_slow
);

    localparam int ROWS         = 1 << MA_W;
    localparam int OFS_W        = CPU_AW - 1;
    localparam int MAX_CYC_CLKS = (SYS_CLK_KHZ * RETENTION_MS) / ROWS;

    logic              phi2_q;
    logic              phi2_rise;
    logic [PAGE_W-1:0] page;
    logic              load_addr;
    amux_sel_t         amux;
    logic [MA_W-1:0]   ref_row;

    // Previous phi2 level, used for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= cpu_phi2;
    end

    assign phi2_rise = cpu_phi2 && !phi2_q;

    bank_page_reg #(
        .CPU_AW  (CPU_AW),
        .CPU_DW  (CPU_DW),
        .PAGE_W  (PAGE_W),
        .MAP_ADDR(MAP_ADDR)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi2   (cpu_phi2),
        .addr   (cpu_addr),
        .rw     (cpu_rw),
        .wdata  (cpu_wdata),
        .page   (page),
        .rd_hit (map_rd_hit),
        .rd_data(map_rd_data)
    );

    bank_access_seq #(
        .REF_CLKS(REF_CLKS),
        .MA_W    (MA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2     (cpu_phi2),
        .phi2_rise(phi2_rise),
        .win_sel  (cpu_addr[CPU_AW-1]),
        .cpu_rw   (cpu_rw),
        .load_addr(load_addr),
        .amux     (amux),
        .ref_row  (ref_row),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n)
    );

    bank_addr_split #(
        .PAGE_W(PAGE_W),
        .OFS_W (OFS_W),
        .MA_W  (MA_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_addr),
        .page   (page),
        .offset (cpu_addr[OFS_W-1:0]),
        .sel    (amux),
        .ref_row(ref_row),
        .ma     (dram_addr)
    );

    bank_rate_mon #(
        .MAX_CYC_CLKS(MAX_CYC_CLKS)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2_rise(phi2_rise),
        .slow     (refresh_slow)
    );

endmodule

// File: rtl/paged_dram_ctrl_chk.sv
// Protocol checker for the DRAM strobes of paged_dram_ctrl.
// Watches only the memory-side ports and is attached by bind.
module paged_dram_ctrl_chk #(
    parameter int MA_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic [MA_W-1:0] dram_addr,
    input logic            dram_ras_n,
    input logic            dram_cas_n,
    input logic            dram_we_n
);

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R5

    AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ($past(!dram_ras_n) && $past(!dram_ras_n, 2))); // R5

    AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> $rose(dram_ras_n)); // R5

    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R6

    AST_WE_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_ras_n); // R6

    AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |=> !dram_ras_n); // R7

    AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr)); // R4

endmodule

bind paged_dram_ctrl paged_dram_ctrl_chk #(.MA_W(MA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dram_addr (dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n)
);

// File: tb/paged_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected strobe edges per processor
// cycle, and the monitor pops and compares them as the edges appear.
module paged_dram_ctrl_tb_top;

    localparam int MAP = 16'h7F00;
    localparam int EV_RR = 0, EV_CR = 1, EV_WR = 2, EV_RF = 3, EV_WF = 4, EV_CF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_phi2 = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic        map_rd_hit;
    logic [7:0]  map_rd_data;
    logic [10:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, refresh_slow;

    always #2 clk = ~clk;

    paged_dram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_phi2(cpu_phi2), .cpu_addr(cpu_addr),
        .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata), .map_rd_hit(map_rd_hit),
        .map_rd_data(map_rd_data), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .refresh_slow(refresh_slow)
    );

    typedef struct {
        int    kind;
        int    k;
        int    addr;
        string req;
    } ev_t;

    ev_t exp_q[$];
    int  total = 0;
    int  bad = 0;
    int  page_m = 0;
    int  ref_m = 0;
    int  refs_done = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input int kd, input int k, input int a, input string r);
        ev_t e;
        e.kind = kd; e.k = k; e.addr = a; e.req = r;
        exp_q.push_back(e);
    endtask

    // Compare one observed strobe edge against the head of the queue
    task automatic observe(input int kd, input int k, input int a);
        ev_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R5 unexpected edge: actual kind=%0d k=%0d addr=%0h expected=none",
                     kd, k, a);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kd || e.k != k || (e.addr >= 0 && e.addr != a)) begin
                bad++;
                $display("FAIL %s edge: actual kind=%0d k=%0d addr=%0h expected kind=%0d k=%0d addr=%0h",
                         e.req, kd, k, a, e.kind, e.k, e.addr);
            end
        end
    endtask

    // Monitor: sample 1 ns after each posedge, track offset since phi2 rise
    initial begin
        logic p_ras, p_cas, p_we, p_phi;
        int   k;
        p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; p_phi = 1'b0; k = 1000;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1; p_phi = 1'b0; k = 1000;
            end else begin
                if (cpu_phi2 && !p_phi) k = 0;
                else                    k++;
                p_phi = cpu_phi2;
                if (dram_ras_n && !p_ras)  observe(EV_RR, k, int'(dram_addr));
                if (dram_cas_n && !p_cas)  observe(EV_CR, k, int'(dram_addr));
                if (dram_we_n && !p_we)    observe(EV_WR, k, int'(dram_addr));
                if (!dram_ras_n && p_ras)  observe(EV_RF, k, int'(dram_addr));
                if (!dram_we_n && p_we)    observe(EV_WF, k, int'(dram_addr));
                if (!dram_cas_n && p_cas)  observe(EV_CF, k, int'(dram_addr));
                p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
            end
        end
    end

    // Driver: one processor cycle, hi clocks high then lo clocks low.
    // Called at a negedge; queues every strobe edge the cycle must produce.
    task automatic cpu_cycle(input int a, input bit rw, input int wd,
                             input int hi, input int lo, input string rtag);
        int phys, row, col, rk;
        if (a >= 32768) begin
            phys = (page_m << 15) | (a & 32'h7FFF);
            row  = phys >> 11;
            col  = phys & 2047;
            push(EV_RF, 1, row, "R4");
            if (!rw) push(EV_WF, 2, col, "R6");
            push(EV_CF, 3, col, "R4");
            push(EV_RR, hi, -1, "R5");
            push(EV_CR, hi, -1, "R5");
            if (!rw) push(EV_WR, hi, -1, "R6");
            rk = hi + 1;
        end else begin
            rk = hi;
        end
        push(EV_RF, rk, ref_m, (ref_m == 0 && refs_done > 0) ? "R8" : "R7");
        push(EV_RR, rk + 2, -1, "R7");
        ref_m = (ref_m + 1) % 2048;
        refs_done++;

        cpu_addr  = 16'(a);
        cpu_rw    = rw;
        cpu_wdata = 8'(wd);
        cpu_phi2  = 1'b1;
        for (int i = 0; i < hi; i++) begin
            @(negedge clk);
            if (i == 0 && a == MAP && rw)
                chk(map_rd_hit && map_rd_data == 8'(page_m), rtag, "page readback",
                    {map_rd_hit, map_rd_data}, {1'b1, 8'(page_m)});
            if (a < 32768 && a != 0)
                chk(dram_ras_n && dram_cas_n, "R3", "strobes idle on low-half access",
                    {dram_ras_n, dram_cas_n}, 2'b11);
        end
        if (a == MAP && !rw) page_m = wd & 127;
        cpu_phi2 = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
        chk(!refresh_slow, "R1", "slow flag in reset", refresh_slow, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_addr == 11'd0, "R1", "refresh row after reset", dram_addr, 0);

        cpu_cycle(MAP, 1'b1, 0, 5, 5, "R1");          // page 0 after reset
        cpu_cycle(16'hC5A7, 1'b1, 0, 5, 5, "R4");     // window read, page 0
        cpu_cycle(MAP, 1'b0, 8'hD5, 5, 5, "R2");      // page 0x55, bit 7 ignored
        cpu_cycle(MAP, 1'b1, 0, 5, 5, "R2");
        cpu_cycle(16'hFFFF, 1'b0, 8'h3C, 5, 5, "R6"); // window write
        cpu_cycle(16'h8000, 1'b1, 0, 7, 6, "R5");     // longer high phase
        cpu_cycle(16'h1234, 1'b0, 8'h11, 5, 5, "R3"); // low half, no strobes
        cpu_cycle(16'h7FFF, 1'b1, 0, 5, 5, "R3");
        cpu_cycle(MAP, 1'b0, 8'h7F, 5, 5, "R2");      // top page
        cpu_cycle(MAP, 1'b1, 0, 5, 5, "R2");
        cpu_cycle(16'hAAAA, 1'b0, 8'h5A, 5, 5, "R4");
        cpu_cycle(16'h9234, 1'b1, 0, 4, 4, "R5");     // minimum high phase
        cpu_cycle(MAP, 1'b0, 8'h00, 5, 5, "R2");

        for (int n = 0; n < 2050; n++)                // counter wraps
            cpu_cycle(0, 1'b1, 0, 5, 5, "R8");
        chk(!refresh_slow, "R9", "flag after fast cycles", refresh_slow, 0);

        cpu_cycle(16'h1000, 1'b1, 0, 5, 239, "R9");   // period 244
        cpu_cycle(16'h1000, 1'b1, 0, 5, 5, "R9");
        chk(!refresh_slow, "R9", "flag after 244-clock period", refresh_slow, 0);
        cpu_cycle(16'h1000, 1'b1, 0, 5, 240, "R9");   // period 245
        cpu_cycle(16'h1000, 1'b1, 0, 5, 5, "R9");
        chk(refresh_slow, "R9", "flag after 245-clock period", refresh_slow, 1);
        cpu_cycle(16'h8001, 1'b1, 0, 5, 5, "R9");
        chk(refresh_slow, "R9", "flag sticky", refresh_slow, 1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "expected edges left", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule